// File: doc/BRIEF.md
# DMA Block Transfer Engine

This block moves data from a source region to a destination region, one whole block per trigger. Software programs a source address, a destination address, a block length in units and a number of blocks. It then sets the enable bit. Each pulse on the request input makes the engine copy one complete block over a single-master memory bus. Every unit is a read from the source address followed by a write of the same data to the destination address. Each access waits for the bus ready signal.

Each address has its own stepping mode. One side is chosen as the block area. After every block, that side's address snaps back to where the block began, and the per-block unit counter reloads from a fixed copy of the programmed length. The other side keeps advancing. This lets a fixed source or target window be reused block after block. When the last block completes, the engine disables itself, drops busy and raises a sticky interrupt. A requester that fires again during a running block is remembered and served next.

Top module: `dma_blk_engine`

## Requirements
- R1: After reset, `bus_rd`, `bus_wr`, `busy` and `done_irq` are all low, and the engine stays disabled.
- R2: One request starts exactly one block of N units, where N is the programmed block length. After the block, the bus stays idle until another request arrives.
- R3: Each unit is one read cycle (`bus_rd`) at the source address, then one write cycle (`bus_wr`) at the destination address carrying the data just read. A byte write carries the read's low byte on `bus_wdata[7:0]` with zero in the upper bits. Each cycle holds its address until it sees `bus_ready` high at a clock edge.
- R4: Register map (`cfg_addr`): 0 holds the source address and 1 the destination address. Control is register 4. Its bits [2:1] set the source mode and [4:3] the destination mode. The modes are: 1 = increment, 2 = decrement, 0 or 3 = hold. Addresses change by 2 when control bit 6 (word units) is set and by 1 otherwise. They wrap modulo 2^24. `bus_word` reflects bit 6.
- R5: Control bit 5 picks the block-area side: 0 for the source, 1 for the destination. At the end of every block, that side's address returns to its value at the start of that block. The other side keeps its stepped value.
- R6: Register 2 sets the block length in units (8 bits). The length is reloaded for every block. A value of 0 means 256 units.
- R7: Register 3 sets the number of blocks (16 bits). When the final block's last write completes, `busy` drops, the enable bit (control bit 0) clears and `done_irq` rises in the same cycle.
- R8: A request that arrives while a block is running is held, and its block starts after the current one without another request.
- R9: While the enable bit is clear, including after the final block, requests are ignored and the bus stays idle.
- R10: `done_irq` stays high until any write to register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 24 | Register write data |
| req | input | 1 | Transfer request, one block per pulse |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read cycle active |
| bus_wr | output | 1 | Write cycle active |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Access completes on a clock edge where this is high |
| busy | output | 1 | A block is in progress |
| done_irq | output | 1 | Sticky completion interrupt |

## Verification
A wrong address step or a missed restore of the block-area address shows on `bus_addr` at the very next read or write cycle. The read data is a function of the address, so a wrong source address also shows as wrong `bus_wdata` one access later. A wrong unit or block count first shows as a `bus_rd` where the bus should be idle, or as a missing one. It can also show as `busy` and `done_irq` changing in the wrong cycle after the final write. A lost pending request shows as a bus that stays idle after the current block ends.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    localparam logic [1:0] STEP_INC = 2'd1;
    localparam logic [1:0] STEP_DEC = 2'd2;

    localparam logic [2:0] REG_SRC   = 3'd0;
    localparam logic [2:0] REG_DST   = 3'd1;
    localparam logic [2:0] REG_SIZE  = 3'd2;
    localparam logic [2:0] REG_COUNT = 3'd3;
    localparam logic [2:0] REG_CTRL  = 3'd4;
    localparam logic [2:0] REG_ACK   = 3'd5;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_SRC  = 1;
    localparam int CTRL_DST  = 3;
    localparam int CTRL_AREA = 5;
    localparam int CTRL_WORD = 6;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_blk_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    input  logic          word_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] stride;

    always_comb begin
        stride = word_i ? AW'(2) : AW'(1);
        case (mode_i)
            STEP_INC: addr_o = addr_i + stride;
            STEP_DEC: addr_o = addr_i - stride;
            default:  addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dma_blk_engine.sv
module dma_blk_engine
    import dma_blk_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int SW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_word,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          busy,
    output logic          done_irq
);
    localparam int BW = 8;

    typedef struct packed {
        dma_state_e    state;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] base;
        logic [SW-1:0] size_cnt;
        logic [SW-1:0] size_init;
        logic [CW-1:0] blk_cnt;
        logic [DW-1:0] data;
        logic          pend;
        logic          en;
        logic          irq;
        logic [1:0]    src_mode;
        logic [1:0]    dst_mode;
        logic          area_dst;
        logic          word;
    } regs_t;

    regs_t q, d;
    logic [AW-1:0] src_next, dst_next;

    dma_addr_step #(.AW(AW)) u_src_step (
        .addr_i (q.src),
        .mode_i (q.src_mode),
        .word_i (q.word),
        .addr_o (src_next)
    );

    dma_addr_step #(.AW(AW)) u_dst_step (
        .addr_i (q.dst),
        .mode_i (q.dst_mode),
        .word_i (q.word),
        .addr_o (dst_next)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (q.en && (req || q.pend)) begin
                    d.state = ST_READ;
                    d.pend  = 1'b0;
                    d.base  = q.area_dst ? q.dst : q.src;
                end
            end
            ST_READ: begin
                if (req && q.en) d.pend = 1'b1;
                if (bus_ready) begin
                    d.data  = bus_rdata;
                    d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (req && q.en) d.pend = 1'b1;
                if (bus_ready) begin
                    d.src      = src_next;
                    d.dst      = dst_next;
                    d.size_cnt = q.size_cnt - 1'b1;
                    d.state    = ST_READ;
                    if (q.size_cnt == SW'(1)) begin
                        d.size_cnt = q.size_init;
                        if (q.area_dst) d.dst = q.base;
                        else            d.src = q.base;
                        d.blk_cnt = q.blk_cnt - 1'b1;
                        d.state   = ST_IDLE;
                        if (q.blk_cnt == CW'(1)) begin
                            d.en   = 1'b0;
                            d.irq  = 1'b1;
                            d.pend = 1'b0;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (cfg_we) begin
            case (cfg_addr)
                REG_SRC:   d.src = cfg_wdata;
                REG_DST:   d.dst = cfg_wdata;
                REG_SIZE: begin
                    d.size_init = cfg_wdata[SW-1:0];
                    d.size_cnt  = cfg_wdata[SW-1:0];
                end
                REG_COUNT: d.blk_cnt = cfg_wdata[CW-1:0];
                REG_CTRL: begin
                    d.en       = cfg_wdata[CTRL_EN];
                    d.src_mode = cfg_wdata[CTRL_SRC +: 2];
                    d.dst_mode = cfg_wdata[CTRL_DST +: 2];
                    d.area_dst = cfg_wdata[CTRL_AREA];
                    d.word     = cfg_wdata[CTRL_WORD];
                    if (!cfg_wdata[CTRL_EN]) d.pend = 1'b0;
                end
                REG_ACK:   d.irq = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rd    = (q.state == ST_READ);
    assign bus_wr    = (q.state == ST_WRITE);
    assign bus_addr  = bus_wr ? q.dst : q.src;
    assign bus_word  = q.word;
    assign bus_wdata = q.word ? q.data : {{(DW-BW){1'b0}}, q.data[BW-1:0]};
    assign busy      = (q.state != ST_IDLE);
    assign done_irq  = q.irq;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready && !cfg_we) |=> (bus_rd && $stable(bus_addr))); // R3
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ready) |=> bus_wr); // R3
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.en)); // R9
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !(cfg_we && cfg_addr == REG_ACK)) |=> done_irq); // R10
    AST_SIZE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready && q.size_cnt == SW'(1) && !cfg_we) |=> (q.size_cnt == q.size_init)); // R6
    AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_irq) && !$past(cfg_we)) |-> (!q.en && !busy)); // R7
endmodule

// File: tb/dma_blk_engine_test.sv
`timescale 1ns/1ps
module dma_blk_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic [23:0] bus_addr;
    logic        bus_rd, bus_wr, bus_word;
    logic [15:0] bus_wdata, bus_rdata;
    logic        bus_ready = 1'b0;
    logic        busy, done_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_blk_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req(req), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy), .done_irq(done_irq)
    );

    function automatic logic [15:0] pat(input logic [23:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
    endfunction

    assign bus_rdata = pat(bus_addr);

    function automatic logic [23:0] step(input logic [23:0] a, input int mode, input bit w);
        logic [23:0] inc;
        inc = w ? 24'd2 : 24'd1;
        if (mode == 1) return a + inc;
        if (mode == 2) return a - inc;
        return a;
    endfunction

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint actual, input longint expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, actual, expected);
        end
    endtask

    // behavioural reference model
    logic [23:0] m_src, m_dst, m_base;
    logic [15:0] m_data;
    int  m_smode, m_dmode, m_size, m_blocks, m_left, m_units, m_last_units;
    bit  m_area_dst, m_word, m_en, m_in, m_wr_phase, m_chk_done;
    int  blocks_done = 0;
    logic [7:0] lfsr = 8'hA7;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_chk_done) begin
                check(done_irq == 1'b1 && busy == 1'b0, "R7", "done/busy after last block",
                      {done_irq, busy}, 2'b10);
                m_chk_done = 0;
            end
            if (!m_in) begin
                if (bus_wr) check(0, "R3", "write outside a block", 1, 0);
                if (bus_rd) begin
                    if (!m_en) check(0, "R9", "read while disabled", 1, 0);
                    m_in = 1; m_wr_phase = 0; m_units = 0;
                    m_base = m_area_dst ? m_dst : m_src;
                    m_left = (m_size == 0) ? 256 : m_size;
                end
            end
            if (m_in) begin
                if (!m_wr_phase)
                    check(bus_rd && !bus_wr && bus_addr == m_src, "R4", "read address",
                          bus_addr, m_src);
                else
                    check(bus_wr && !bus_rd && bus_addr == m_dst &&
                          bus_wdata == (m_word ? m_data : {8'h00, m_data[7:0]}),
                          "R3", "write address/data", {bus_addr, bus_wdata},
                          {m_dst, (m_word ? m_data : {8'h00, m_data[7:0]})});
                check(bus_word == m_word, "R4", "unit size", bus_word, m_word);
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bus_ready = lfsr[0] | lfsr[1];
            if (m_in && bus_ready) begin
                if (!m_wr_phase) begin
                    m_data = pat(m_src);
                    m_wr_phase = 1;
                end else begin
                    m_src = step(m_src, m_smode, m_word);
                    m_dst = step(m_dst, m_dmode, m_word);
                    m_left--; m_units++;
                    m_wr_phase = 0;
                    if (m_left == 0) begin
                        if (m_area_dst) m_dst = m_base; else m_src = m_base;
                        m_blocks--; blocks_done++; m_last_units = m_units; m_in = 0;
                        if (m_blocks == 0) begin m_en = 0; m_chk_done = 1; end
                    end
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [23:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic setup(input logic [23:0] s, input logic [23:0] dd, input int sm, input int dm,
                         input bit area, input bit w, input int sz, input int cnt);
        wr(3'd0, s); wr(3'd1, dd); wr(3'd2, 24'(sz)); wr(3'd3, 24'(cnt));
        m_src = s; m_dst = dd; m_smode = sm; m_dmode = dm; m_area_dst = area;
        m_word = w; m_size = sz; m_blocks = cnt; m_en = 1;
        wr(3'd4, {17'd0, w, area, 2'(dm), 2'(sm), 1'b1});
    endtask

    task automatic wait_blocks(input int target);
        while (blocks_done < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "WATCHDOG", "run timed out", 0, 1);
        finish_run();
    end

    initial begin
        m_in = 0; m_en = 0; m_chk_done = 0; m_wr_phase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_rd && !bus_wr && !busy && !done_irq, "R1", "reset outputs",
              {bus_rd, bus_wr, busy, done_irq}, 0);
        pulse_req();
        repeat (5) @(negedge clk);
        check(!busy && !bus_rd, "R1", "disabled after reset", busy, 0);

        // byte units, both increment, source is block area, 4 units x 2 blocks
        setup(24'h001000, 24'h002000, 1, 1, 0, 0, 4, 2);
        pulse_req();
        wait_blocks(1);
        repeat (10) @(negedge clk);
        check(!busy && !bus_rd, "R2", "idle after one block", busy, 0);
        check(m_last_units == 4, "R2", "units in block", m_last_units, 4);
        check(!done_irq, "R7", "no irq before last block", done_irq, 0);
        pulse_req();
        wait_blocks(2);
        check(m_last_units == 4, "R6", "length reloaded", m_last_units, 4);
        repeat (6) @(negedge clk);
        check(done_irq, "R10", "irq held", done_irq, 1);
        pulse_req();
        repeat (20) begin
            @(negedge clk);
            check(!bus_rd && !busy, "R9", "request after end ignored", {bus_rd, busy}, 0);
        end
        wr(3'd5, 24'd0);
        check(!done_irq, "R10", "irq cleared by write", done_irq, 0);

        // word units, source decrement, destination area, pending request
        setup(24'h000104, 24'h003000, 2, 1, 1, 1, 3, 3);
        pulse_req();
        repeat (2) @(negedge clk);
        check(busy, "R8", "block running", busy, 1);
        pulse_req();
        wait_blocks(4);
        repeat (12) @(negedge clk);
        check(!busy && !done_irq, "R8", "pending served once", {busy, done_irq}, 0);
        pulse_req();
        wait_blocks(5);
        repeat (2) @(negedge clk);
        check(done_irq, "R7", "irq after third block", done_irq, 1);
        wr(3'd5, 24'd0);

        // length 0 = 256 units, source hold (mode 3), destination decrement wraps
        setup(24'h00ABCD, 24'h000010, 3, 2, 0, 0, 0, 1);
        pulse_req();
        wait_blocks(6);
        check(m_last_units == 256, "R6", "length 0 means 256", m_last_units, 256);
        repeat (2) @(negedge clk);
        wr(3'd5, 24'd0);

        // word units, source hold (mode 0), destination area increments
        setup(24'h000200, 24'h004000, 0, 1, 1, 1, 2, 2);
        pulse_req();
        pulse_req();
        wait_blocks(8);
        repeat (3) @(negedge clk);
        check(done_irq && !busy, "R5", "area run complete", {done_irq, busy}, 2'b10);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule